// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point numbers and returns their packed 32-bit product one clock after the operands are presented. Each word is laid out from the most significant bit down as one sign bit, an 8-bit biased exponent and a 23-bit fraction. The fraction sits behind an implied leading one. The block restores that leading one, multiplies the two 24-bit significands into a 48-bit product and adds the exponents with one bias removed. It then shifts the product right by at most one place, rounds it to nearest-even using guard, round and sticky bits, and shifts once more if rounding carries into a new leading bit.

An operand whose exponent field is zero counts as zero. Subnormals are therefore flushed, and the result is a signed zero that does not depend on the multiply path. Results too large for the format become infinity with the computed sign. Results too small become a signed zero. Flags report each of these cases. Operands that encode infinity or NaN are outside the block's scope. There is no handshake: a valid strobe travels alongside the data with a fixed latency of one cycle.

Top module: `fpmul_sp`

## Requirements
- R1: The result word has the sign in bit 31, the biased exponent (bias 127) in bits 30:23 and the fraction in bits 22:0. A finite nonzero result always has an exponent field between 1 and 254.
- R2: The result sign equals the XOR of the two operand signs in every case, including zero, overflow and underflow results.
- R3: For normal operands, the result exponent field is Ea + Eb - 127, plus any normalization adjustment. The significands multiplied are the fractions with the implied leading one restored (e.g. 0x3FC00000 x 0x40000000 = 0x40400000).
- R4: When the significand product is 2.0 or more, it is shifted right one place and the exponent is raised by one (e.g. 0x3FC00000 x 0x3FC00000 = 0x40100000).
- R5: Rounding is to nearest, with ties going to the even value. Bits below the round position are OR-ed into a sticky bit. A tie rounds up when the kept LSB is 1 (0x3F800001 x 0x3FC00000 = 0x3FC00002) and down when it is 0 (0x3F800003 x 0x3FC00000 = 0x3FC00004).
- R6: If rounding carries the significand up to 2.0, the result is shifted right again and the exponent incremented (0x3FFFFFFE x 0x3F800001 = 0x40000000).
- R7: If either operand has a zero exponent field (zero or subnormal), the result is a signed zero with `zero` = 1 and both other flags 0.
- R8: A final exponent of 255 or more sets `overflow` and returns infinity: exponent field 0xFF, fraction 0, computed sign.
- R9: A final exponent of 0 or less sets `underflow` and `zero` and returns a signed zero. An exponent of exactly 1 is still a normal result.
- R10: `out_valid` is `in_valid` delayed by one clock. Synchronous active-high reset clears `out_valid`, `p` and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands a and b are valid this cycle |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| out_valid | output | 1 | p and flags hold a new result |
| p | output | 32 | Packed product |
| overflow | output | 1 | Result exponent too large; p is infinity |
| underflow | output | 1 | Result exponent too small; p is zero |
| zero | output | 1 | p is a signed zero (zero operand or underflow) |

## Verification
The assertions assume that `in_valid`, `a` and `b` are known at every clock edge after reset. They also assume that no operand carries an exponent field of 255, since infinity and NaN are outside the block's scope. The stimulus respects both. Every operand, whether fixed or pseudo-random, has its exponent field forced into 0..254, and the driver always leaves the inputs at defined values, even during idle cycles. Zero and subnormal operands are still applied, because the block is required to flush them.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

   typedef struct packed {
      logic ovf;
      logic unf;
      logic zro;
   } fpm_flags_t;

   function automatic int unsigned fpm_bias(input int unsigned exp_w);
      return (1 << (exp_w - 1)) - 1;
   endfunction

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int SIG_W = FRAC_W + 1
) (
   input  logic [W-1:0]     op,
   output logic             sgn,
   output logic [EXP_W-1:0] expo,
   output logic [SIG_W-1:0] sig,
   output logic             is_zero
);
   assign sgn     = op[W-1];
   assign expo    = op[W-2 -: EXP_W];
   assign is_zero = (expo == '0);
   assign sig     = {~is_zero, op[FRAC_W-1:0]};
endmodule

// File: rtl/fpm_sigmul.sv
module fpm_sigmul #(
   parameter int SIG_W   = 24,
   localparam int PROD_W = 2 * SIG_W
) (
   input  logic [SIG_W-1:0]  sa,
   input  logic [SIG_W-1:0]  sb,
   output logic [PROD_W-1:0] prod
);
   assign prod = PROD_W'(sa) * PROD_W'(sb);
endmodule

// File: rtl/fpm_normround.sv
module fpm_normround
   import fpm_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   localparam int SIG_W  = FRAC_W + 1,
   localparam int PROD_W = 2 * SIG_W,
   localparam int EW     = EXP_W + 2,
   localparam int EMAX   = (1 << EXP_W) - 1
) (
   input  logic [PROD_W-1:0]   prod,
   input  logic signed [EW-1:0] esum,
   output logic [EXP_W-1:0]    exp_out,
   output logic [FRAC_W-1:0]   frac_out,
   output fpm_flags_t          flg
);
   logic             hi;
   logic [SIG_W-1:0] kept;
   logic             gbit, rbit, sbit, bump;
   logic [SIG_W:0]   rsum, rshift;
   logic             carry;
   logic signed [EW-1:0] adj_hi, adj_cy, efin;

   assign hi = prod[PROD_W-1];

   // one-place normalization with guard/round/sticky capture
   always_comb begin
      if (hi) begin
         kept = prod[PROD_W-1 -: SIG_W];
         gbit = prod[PROD_W-1-SIG_W];
         rbit = prod[PROD_W-2-SIG_W];
         sbit = |prod[PROD_W-3-SIG_W:0];
      end else begin
         kept = prod[PROD_W-2 -: SIG_W];
         gbit = prod[PROD_W-2-SIG_W];
         rbit = prod[PROD_W-3-SIG_W];
         sbit = |prod[PROD_W-4-SIG_W:0];
      end
   end

   // nearest-even increment and post-round renormalization
   assign bump   = gbit & (rbit | sbit | kept[0]);
   assign rsum   = {1'b0, kept} + (SIG_W+1)'(bump);
   assign carry  = rsum[SIG_W];
   assign rshift = carry ? (rsum >> 1) : rsum;

   assign adj_hi = signed'(EW'(hi));
   assign adj_cy = signed'(EW'(carry));
   assign efin   = esum + adj_hi + adj_cy;

   always_comb begin
      flg      = '0;
      exp_out  = efin[EXP_W-1:0];
      frac_out = rshift[FRAC_W-1:0];
      if (efin >= signed'(EW'(EMAX))) begin
         flg.ovf  = 1'b1;
         exp_out  = '1;
         frac_out = '0;
      end else if (efin <= signed'(EW'(0))) begin
         flg.unf  = 1'b1;
         flg.zro  = 1'b1;
         exp_out  = '0;
         frac_out = '0;
      end
   end
endmodule

// File: rtl/fpmul_sp.sv
module fpmul_sp
   import fpm_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   localparam int W      = 1 + EXP_W + FRAC_W,
   localparam int SIG_W  = FRAC_W + 1,
   localparam int PROD_W = 2 * SIG_W,
   localparam int EW     = EXP_W + 2,
   localparam int BIAS   = int'(fpm_bias(EXP_W))
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         out_valid,
   output logic [W-1:0] p,
   output logic         overflow,
   output logic         underflow,
   output logic         zero
);
   generate
      if (EXP_W < 3)  begin : g_bad_exp  $error("fpmul_sp: EXP_W must be at least 3");  end
      if (FRAC_W < 3) begin : g_bad_frac $error("fpmul_sp: FRAC_W must be at least 3"); end
   endgenerate

   logic [W-1:0]     ops [2];
   logic             op_s [2];
   logic [EXP_W-1:0] op_e [2];
   logic [SIG_W-1:0] op_m [2];
   logic             op_z [2];

   assign ops[0] = a;
   assign ops[1] = b;

   generate
      for (genvar i = 0; i < 2; i++) begin : g_unpack
         fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
            .op(ops[i]), .sgn(op_s[i]), .expo(op_e[i]),
            .sig(op_m[i]), .is_zero(op_z[i])
         );
      end
   endgenerate

   logic [PROD_W-1:0]    prod;
   logic [EW-1:0]        eraw;
   logic signed [EW-1:0] esum;
   logic [EXP_W-1:0]     e_n;
   logic [FRAC_W-1:0]    f_n;
   fpm_flags_t           flg_n;
   logic                 s_n, any_zero;

   fpm_sigmul #(.SIG_W(SIG_W)) u_mul (.sa(op_m[0]), .sb(op_m[1]), .prod(prod));

   assign eraw = EW'(op_e[0]) + EW'(op_e[1]) - EW'(BIAS);
   assign esum = signed'(eraw);

   fpm_normround #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nr (
      .prod(prod), .esum(esum), .exp_out(e_n), .frac_out(f_n), .flg(flg_n)
   );

   assign s_n      = op_s[0] ^ op_s[1];
   assign any_zero = op_z[0] | op_z[1];

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         p         <= '0;
         overflow  <= 1'b0;
         underflow <= 1'b0;
         zero      <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            if (any_zero) begin
               p         <= {s_n, {(W-1){1'b0}}};
               overflow  <= 1'b0;
               underflow <= 1'b0;
               zero      <= 1'b1;
            end else begin
               p         <= {s_n, e_n, f_n};
               overflow  <= flg_n.ovf;
               underflow <= flg_n.unf;
               zero      <= flg_n.zro;
            end
         end
      end
   end

   // ---------------- assertions ----------------
   assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   assert_valid_idle_R10: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   assert_sign_xor_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> p[W-1] == $past(a[W-1] ^ b[W-1]));
   assert_zero_operand_R7: assert property (@(posedge clk) disable iff (rst)
      in_valid && (a[W-2 -: EXP_W] == '0 || b[W-2 -: EXP_W] == '0)
      |=> zero && !overflow && !underflow && p[W-2:0] == '0);
   assert_inf_encoding_R8: assert property (@(posedge clk) disable iff (rst)
      overflow |-> p[W-2 -: EXP_W] == '1 && p[FRAC_W-1:0] == '0 && !zero);
   assert_flush_result_R9: assert property (@(posedge clk) disable iff (rst)
      underflow |-> zero && p[W-2:0] == '0);
   assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot0({overflow, underflow}));
   assert_normal_range_R1: assert property (@(posedge clk) disable iff (rst)
      out_valid && !zero && !overflow |-> p[W-2 -: EXP_W] != '0 && p[W-2 -: EXP_W] != '1);
endmodule

// File: tb/fpmul_sp_tb_top.sv
`timescale 1ns/1ps
module fpmul_sp_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] a = '0, b = '0;
   logic        out_valid, overflow, underflow, zero;
   logic [31:0] p;

   always #4 clk = ~clk;

   fpmul_sp dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
      .out_valid(out_valid), .p(p), .overflow(overflow),
      .underflow(underflow), .zero(zero)
   );

   typedef struct {
      logic [31:0] ep;
      logic [2:0]  ef;   // {overflow, underflow, zero}
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   // independent reference: integer quotient/remainder rounding
   function automatic logic [34:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
      logic s = x[31] ^ y[31];
      int   ex = int'(x[30:23]);
      int   ey = int'(y[30:23]);
      longint unsigned mx, my, pr, q, rem, half;
      int   sh, e;
      if (ex == 0 || ey == 0) return {s, 31'b0, 3'b001};
      mx = {40'd0, 1'b1, x[22:0]};
      my = {40'd0, 1'b1, y[22:0]};
      pr = mx * my;
      sh = pr[47] ? 24 : 23;
      e  = ex + ey - 127 + (pr[47] ? 1 : 0);
      q    = pr >> sh;
      rem  = pr & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      if (rem > half || (rem == half && q[0])) q = q + 1;
      if (q == (64'd1 << 24)) begin q = q >> 1; e = e + 1; end
      if (e >= 255) return {s, 8'hFF, 23'b0, 3'b100};
      if (e <= 0)   return {s, 31'b0, 3'b011};
      return {s, e[7:0], q[22:0], 3'b000};
   endfunction

   task automatic drive(input logic [31:0] x, input logic [31:0] y,
                        input logic [34:0] expv, input string tag);
      exp_t it;
      @(negedge clk);
      a = x; b = y; in_valid = 1'b1;
      it.ep = expv[34:3]; it.ef = expv[2:0]; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic drive_ref(input logic [31:0] x, input logic [31:0] y, input string tag);
      drive(x, y, ref_mul(x, y), tag);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst && !done && out_valid) begin
         exp_t it;
         n_chk++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R10: out_valid with nothing pending (actual 1, expected 0)");
         end else begin
            it = exp_q.pop_front();
            if (p !== it.ep || {overflow, underflow, zero} !== it.ef) begin
               n_bad++;
               $display("FAIL %s: actual p=%08h flags=%03b expected p=%08h flags=%03b",
                        it.tag, p, {overflow, underflow, zero}, it.ep, it.ef);
            end
         end
      end
   end

   task automatic check_quiet(input string tag);
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL %s: out_valid actual %b expected 0", tag, out_valid);
      end
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not end (actual hung, expected done)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   logic [31:0] lfsr = 32'h1D2C3B4A;
   function automatic logic [31:0] nxt(input logic [31:0] v);
      logic [31:0] t = v;
      t ^= t << 13; t ^= t >> 17; t ^= t << 5;
      return t;
   endfunction

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0 || p !== '0 || {overflow, underflow, zero} !== 3'b000) begin
         n_bad++;
         $display("FAIL R10 reset: actual v=%b p=%08h flags=%03b expected 0/0/000",
                  out_valid, p, {overflow, underflow, zero});
      end
      rst = 1'b0;
      check_quiet("R10 idle after reset");

      // directed vectors (hand-derived expectations)
      drive(32'h3FC00000, 32'h40000000, {32'h40400000, 3'b000}, "R3 1.5x2");
      drive(32'hBFC00000, 32'h40000000, {32'hC0400000, 3'b000}, "R2 sign");
      drive(32'hBF800000, 32'hBF800000, {32'h3F800000, 3'b000}, "R2 neg x neg");
      drive(32'h3FC00000, 32'h3FC00000, {32'h40100000, 3'b000}, "R4 normalize");
      drive(32'h3F800001, 32'h3FC00000, {32'h3FC00002, 3'b000}, "R5 tie odd up");
      drive(32'h3F800003, 32'h3FC00000, {32'h3FC00004, 3'b000}, "R5 tie even down");
      drive(32'h3FFFFFFE, 32'h3F800001, {32'h40000000, 3'b000}, "R6 round carry");
      drive(32'h00000000, 32'h40400000, {32'h00000000, 3'b001}, "R7 +zero");
      drive(32'h80000000, 32'h40400000, {32'h80000000, 3'b001}, "R7 -zero");
      drive(32'h3F800000, 32'h00000001, {32'h00000000, 3'b001}, "R7 subnormal flush");
      drive(32'h7F000000, 32'h40000000, {32'h7F800000, 3'b100}, "R8 overflow");
      drive(32'hFF000000, 32'h40000000, {32'hFF800000, 3'b100}, "R8 -overflow");
      drive(32'h7F7FFFFF, 32'h3F800000, {32'h7F7FFFFF, 3'b000}, "R1 max finite");
      drive(32'h00800000, 32'h00800000, {32'h00000000, 3'b011}, "R9 underflow");
      drive(32'h9F800000, 32'h20000000, {32'h80000000, 3'b011}, "R9 -underflow edge");
      drive(32'h20000000, 32'h20000000, {32'h00800000, 3'b000}, "R9 min normal");
      idle();
      check_quiet("R10 bubble");

      // pseudo-random, moderate exponents, occasional bubbles
      for (int i = 0; i < 1500; i++) begin
         logic [31:0] x, y;
         lfsr = nxt(lfsr); x = {lfsr[31], 8'(64 + (lfsr[30:23] % 127)), lfsr[22:0]};
         lfsr = nxt(lfsr); y = {lfsr[31], 8'(64 + (lfsr[30:23] % 127)), lfsr[22:0]};
         drive_ref(x, y, "R5 random");
         if (lfsr[3:0] == 4'h0) idle();
      end
      // pseudo-random, full exponent range 0..254
      for (int i = 0; i < 1500; i++) begin
         logic [31:0] x, y;
         lfsr = nxt(lfsr); x = {lfsr[31], 8'(lfsr[30:23] % 255), lfsr[22:0]};
         lfsr = nxt(lfsr); y = {lfsr[31], 8'(lfsr[30:23] % 255), lfsr[22:0]};
         drive_ref(x, y, "R8 R9 random range");
      end
      idle();
      check_quiet("R10 drain");
      repeat (2) @(negedge clk);
      n_chk++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R10: results missing actual %0d pending expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule